// File: doc/BRIEF.md
# Two-wire switch management master

This block drives the management port of an Ethernet switch over a two-wire bus: one clock line and one bidirectional data line. A host pulses a start request with an operation select, a 16-bit register address, 16-bit write data and a flag that drops the last acknowledge check. The block frames the transfer with its own start and stop waveforms and shifts the bytes out and in. It checks every acknowledge bit the switch returns and answers the two read-data bytes itself. At the end it reports read data and a timeout flag together with a one-cycle done pulse.

Every line step lasts one half-bit time of `HALF_CYC` system clocks. The command byte values for reads and writes are parameters. The clock line and the data line each have their own output enable. When the block is idle, both enables are low and both lines are left to their pull-ups.

The controller walks through these states. IDLE accepts a start. START plays the six-step opening waveform. SEND shifts out one byte. ACKCHK polls the switch acknowledge. RECV shifts in one read-data byte. MACK drives the master acknowledge. STOP plays the seven-step closing waveform. DONE raises done for one cycle. The transitions are:
- IDLE→START when start is accepted.
- START→SEND after the sixth step.
- SEND→ACKCHK after bit 0, or SEND→STOP when the final write byte is sent in no-ack mode.
- ACKCHK→SEND for the next outbound byte.
- ACKCHK→RECV after the last address byte of a read.
- ACKCHK→STOP after the last write byte, or on a timeout.
- RECV→MACK after bit 0.
- MACK→RECV after the low byte, or MACK→STOP after the high byte.
- STOP→DONE after the seventh step.
- DONE→IDLE after one cycle.

Top module: `mgmt2w_master`

## Requirements
- R1: After reset, busy, done, err and rdata are 0, and all four line outputs (clock, clock enable, data, data enable) are 0. Whenever busy is low, both enables stay low.
- R2: A transfer opens with six half-bit steps, each given as (clock, data) with both lines driven: (0,1), (1,1), (0,1), (1,1), (1,0), (0,0).
- R3: Each outbound bit goes out most significant bit first and spans three half-bit steps: two with the clock low and one with the clock high. The data line carries the bit for all three steps.
- R4: An inbound bit spans two half-bit steps: the clock is low and then high, and the data enable is low for both. The data input is sampled on the final system clock of the high step.
- R5: A read sends the read command byte, then address bits 7:0, then address bits 15:8. It then receives data bits 7:0 and answers with a driven 0 acknowledge bit. It then receives data bits 15:8 and answers with a driven 1 acknowledge bit. rdata becomes {high byte, low byte}.
- R6: A write sends the write command byte, then the address low byte, the address high byte, the data low byte and the data high byte, each followed by an acknowledge check.
- R7: An acknowledge bit read as 0 passes. A 1 makes the block poll again. After the first poll and `ACK_RETRIES` (default 5) further polls all read 1, the transfer ends with err set to 1, and it still closes with the stop waveform.
- R8: In no-ack mode, a write skips the acknowledge check after the data high byte and goes straight to the stop waveform.
- R9: A transfer closes with seven half-bit steps, each given as (clock, data): (0,0), (1,0), (1,1), (0,1), (1,1), (0,1), (1,1). After that both lines are released.
- R10: Busy rises on the cycle after an accepted start. Busy stays high through a one-cycle done pulse. Start requests are ignored while busy.
- R11: err and rdata change only on the cycle in which done is high. rdata changes only after a read that completes without a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only while idle |
| wr_i | input | 1 | 1 = write transfer, 0 = read transfer |
| addr_i | input | 16 | Register address |
| wdata_i | input | 16 | Write data |
| noack_i | input | 1 | Skip the acknowledge check after the final write byte |
| rdata_o | output | 16 | Read data of the last successful read |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| err_o | output | 1 | Acknowledge timeout of the last transfer |
| mdc_o | output | 1 | Clock line level |
| mdc_oe_o | output | 1 | Clock line drive enable |
| md_o | output | 1 | Data line level |
| md_oe_o | output | 1 | Data line drive enable |
| md_i | input | 1 | Data line sampled level |

## Verification
The assertions assume that start_i is driven with a defined level on every clock edge. Busy can only rise one cycle after start was high. The assertions also assume that md_i is settled before each sampling edge. The bench changes md_i and start_i only at falling edges, so each value holds for a whole cycle around the rising edge. Start pulses with unrelated operands are injected in the middle of a transfer to show that they are dropped.

// File: rtl/mgmt2w_pkg.sv
package mgmt2w_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SEND,
        ST_ACKCHK,
        ST_RECV,
        ST_MACK,
        ST_STOP,
        ST_DONE
    } m2w_state_e;

    localparam logic [2:0] START_LAST = 3'd5;
    localparam logic [2:0] SEND_LAST  = 3'd2;
    localparam logic [2:0] STOP_LAST  = 3'd6;
    localparam logic [2:0] MSB_BIT    = 3'd7;
endpackage

// File: rtl/mgmt2w_half_timer.sv
module mgmt2w_half_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mgmt2w_byte_plan.sv
module mgmt2w_byte_plan
    import mgmt2w_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CMD_RD = 8'hA9,
    parameter logic [BYTE_W-1:0] CMD_WR = 8'hA8
) (
    input  logic              wr,
    input  logic [WORD_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [2:0]        idx,
    output logic [BYTE_W-1:0] byte_o,
    output logic              last_o
);
    always_comb begin
        unique case (idx)
            3'd0:    byte_o = wr ? CMD_WR : CMD_RD;
            3'd1:    byte_o = addr[7:0];
            3'd2:    byte_o = addr[15:8];
            3'd3:    byte_o = wdata[7:0];
            default: byte_o = wdata[15:8];
        endcase
        last_o = wr ? (idx == 3'd4) : (idx == 3'd2);
    end
endmodule

// File: rtl/mgmt2w_master.sv
module mgmt2w_master
    import mgmt2w_pkg::*;
#(
    parameter int                HALF_CYC    = 4,
    parameter int                ACK_RETRIES = 5,
    parameter logic [BYTE_W-1:0] CMD_RD      = 8'hA9,
    parameter logic [BYTE_W-1:0] CMD_WR      = 8'hA8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              noack_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              mdc_o,
    output logic              mdc_oe_o,
    output logic              md_o,
    output logic              md_oe_o,
    input  logic              md_i
);
    localparam int RW = (ACK_RETRIES > 0) ? $clog2(ACK_RETRIES + 1) : 1;
    localparam logic [RW-1:0] RETRY_MAX = RW'(ACK_RETRIES);

    m2w_state_e        state;
    logic [2:0]        step;
    logic [2:0]        bitn;
    logic [2:0]        idx;
    logic [RW-1:0]     retry;
    logic              hi_sel;
    logic              is_wr;
    logic              noack_q;
    logic              err_pend;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] tx_byte;
    logic              last_byte;
    logic              tick;
    logic              run;

    assign run = (state != ST_IDLE) && (state != ST_DONE);

    mgmt2w_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    mgmt2w_byte_plan #(.CMD_RD(CMD_RD), .CMD_WR(CMD_WR)) u_plan (
        .wr     (is_wr),
        .addr   (addr_q),
        .wdata  (wdata_q),
        .idx    (idx),
        .byte_o (tx_byte),
        .last_o (last_byte)
    );

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step     <= '0;
            bitn     <= '0;
            idx      <= '0;
            retry    <= '0;
            hi_sel   <= 1'b0;
            is_wr    <= 1'b0;
            noack_q  <= 1'b0;
            err_pend <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            shreg    <= '0;
            lo_q     <= '0;
            rdata_o  <= '0;
            err_o    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state    <= ST_START;
                        step     <= '0;
                        idx      <= '0;
                        hi_sel   <= 1'b0;
                        err_pend <= 1'b0;
                        is_wr    <= wr_i;
                        noack_q  <= noack_i;
                        addr_q   <= addr_i;
                        wdata_q  <= wdata_i;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (step == START_LAST) begin
                            state <= ST_SEND;
                            step  <= '0;
                            bitn  <= MSB_BIT;
                        end else begin
                            step <= step + 3'd1;
                        end
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (step != SEND_LAST) begin
                            step <= step + 3'd1;
                        end else begin
                            step <= '0;
                            if (bitn != 3'd0) begin
                                bitn <= bitn - 3'd1;
                            end else if (last_byte && is_wr && noack_q) begin
                                state <= ST_STOP;
                            end else begin
                                state <= ST_ACKCHK;
                                retry <= '0;
                            end
                        end
                    end
                end
                ST_ACKCHK: begin
                    if (tick) begin
                        if (step == 3'd0) begin
                            step <= 3'd1;
                        end else begin
                            step <= '0;
                            if (!md_i) begin
                                if (!last_byte) begin
                                    idx   <= idx + 3'd1;
                                    state <= ST_SEND;
                                    bitn  <= MSB_BIT;
                                end else if (is_wr) begin
                                    state <= ST_STOP;
                                end else begin
                                    state <= ST_RECV;
                                    bitn  <= MSB_BIT;
                                end
                            end else if (retry == RETRY_MAX) begin
                                err_pend <= 1'b1;
                                state    <= ST_STOP;
                            end else begin
                                retry <= retry + 1'b1;
                            end
                        end
                    end
                end
                ST_RECV: begin
                    if (tick) begin
                        if (step == 3'd0) begin
                            step <= 3'd1;
                        end else begin
                            step  <= '0;
                            shreg <= {shreg[BYTE_W-2:0], md_i};
                            if (bitn != 3'd0) begin
                                bitn <= bitn - 3'd1;
                            end else begin
                                state <= ST_MACK;
                            end
                        end
                    end
                end
                ST_MACK: begin
                    if (tick) begin
                        if (step != SEND_LAST) begin
                            step <= step + 3'd1;
                        end else begin
                            step <= '0;
                            if (!hi_sel) begin
                                hi_sel <= 1'b1;
                                lo_q   <= shreg;
                                state  <= ST_RECV;
                                bitn   <= MSB_BIT;
                            end else begin
                                state <= ST_STOP;
                            end
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (step != STOP_LAST) begin
                            step <= step + 3'd1;
                        end else begin
                            step  <= '0;
                            state <= ST_DONE;
                            err_o <= err_pend;
                            if (!is_wr && !err_pend) begin
                                rdata_o <= {shreg, lo_q};
                            end
                        end
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Line and handshake outputs
    always_comb begin
        mdc_o    = 1'b0;
        mdc_oe_o = 1'b0;
        md_o     = 1'b0;
        md_oe_o  = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: begin
            end
            ST_START: begin
                mdc_oe_o = 1'b1;
                mdc_o    = (step == 3'd1) || (step == 3'd3) || (step == 3'd4);
                md_oe_o  = 1'b1;
                md_o     = (step < 3'd4);
            end
            ST_SEND: begin
                mdc_oe_o = 1'b1;
                mdc_o    = (step == SEND_LAST);
                md_oe_o  = 1'b1;
                md_o     = tx_byte[bitn];
            end
            ST_ACKCHK, ST_RECV: begin
                mdc_oe_o = 1'b1;
                mdc_o    = (step == 3'd1);
            end
            ST_MACK: begin
                mdc_oe_o = 1'b1;
                mdc_o    = (step == SEND_LAST);
                md_oe_o  = 1'b1;
                md_o     = hi_sel;
            end
            ST_STOP: begin
                mdc_oe_o = 1'b1;
                mdc_o    = (step == 3'd1) || (step == 3'd2) || (step == 3'd4) || (step == 3'd6);
                md_oe_o  = 1'b1;
                md_o     = (step >= 3'd2);
            end
            default: begin
            end
        endcase
    end

    assign busy_o = (state != ST_IDLE);
    assign done_o = (state == ST_DONE);
endmodule

// File: rtl/mgmt2w_master_chk.sv
module mgmt2w_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        err_o,
    input logic [15:0] rdata_o,
    input logic        mdc_oe_o,
    input logic        md_oe_o
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R1
    released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_oe_o && !md_oe_o));

    // R4
    clock_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |-> mdc_oe_o);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_o) |-> done_o);

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_o) |-> done_o);
endmodule

bind mgmt2w_master mgmt2w_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .rdata_o  (rdata_o),
    .mdc_oe_o (mdc_oe_o),
    .md_oe_o  (md_oe_o)
);

// File: tb/mgmt2w_master_tb.sv
module mgmt2w_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 3;
    localparam logic [7:0] C_RD = 8'hA9;
    localparam logic [7:0] C_WR = 8'hA8;

    typedef struct packed {
        logic       ck_oe;
        logic       ck;
        logic       d_oe;
        logic       d;
        logic       slv;
        logic [3:0] req;
    } step_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        noack_i = 1'b0;
    logic        md_i = 1'b1;
    logic [15:0] rdata_o;
    logic        busy_o, done_o, err_o, mdc_o, mdc_oe_o, md_o, md_oe_o;

    int    checks = 0;
    int    errors = 0;
    step_t q[$];
    logic [15:0] exp_rdata = '0;
    logic        exp_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt2w_master #(.HALF_CYC(HALF), .ACK_RETRIES(5), .CMD_RD(C_RD), .CMD_WR(C_WR)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .noack_i(noack_i), .rdata_o(rdata_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .mdc_o(mdc_o), .mdc_oe_o(mdc_oe_o),
        .md_o(md_o), .md_oe_o(md_oe_o), .md_i(md_i)
    );

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input int req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s got %h exp %h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic push(input logic a, input logic b, input logic c, input logic d, input logic s, input int r);
        step_t e;
        e.ck_oe = a; e.ck = b; e.d_oe = c; e.d = d; e.slv = s; e.req = 4'(r);
        q.push_back(e);
    endtask

    // R3: outbound byte, MSB first, three half-bits per bit
    task automatic add_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            push(1, 0, 1, b[i], 1, 3);
            push(1, 0, 1, b[i], 1, 3);
            push(1, 1, 1, b[i], 1, 3);
        end
    endtask

    // R7 retries then R4 passing acknowledge; returns timeout
    task automatic add_ack(input int n, output bit to);
        to = 0;
        for (int k = 0; k < n && k < 6; k++) begin
            push(1, 0, 0, 0, 1, 7);
            push(1, 1, 0, 0, 1, 7);
        end
        if (n >= 6) to = 1;
        else begin
            push(1, 0, 0, 0, 0, 4);
            push(1, 1, 0, 0, 0, 4);
        end
    endtask

    // R5: inbound data byte and master acknowledge
    task automatic add_rd(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            push(1, 0, 0, 0, v[i], 5);
            push(1, 1, 0, 0, v[i], 5);
        end
    endtask

    task automatic add_mack(input logic a);
        push(1, 0, 1, a, 1, 5);
        push(1, 0, 1, a, 1, 5);
        push(1, 1, 1, a, 1, 5);
    endtask

    task automatic idle_check(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({12'd0, mdc_oe_o, md_oe_o, mdc_o, md_o}, 16'd0, 1, "idle lines");
            chk({14'd0, busy_o, done_o}, 16'd0, 10, "idle busy/done");
        end
    endtask

    task automatic run_txn(input bit wr, input logic [15:0] addr, input logic [15:0] wd,
                           input bit noack, input int n0, input int n1, input int n2,
                           input int n3, input int n4, input logic [15:0] rval, input bit poke);
        logic [7:0] bytes [5];
        int         nk [5];
        int         nb;
        bit         to;
        int         cyc;
        q.delete();
        bytes[0] = wr ? C_WR : C_RD;
        bytes[1] = addr[7:0];  bytes[2] = addr[15:8];
        bytes[3] = wd[7:0];    bytes[4] = wd[15:8];
        nk[0] = n0; nk[1] = n1; nk[2] = n2; nk[3] = n3; nk[4] = n4;
        nb = wr ? 5 : 3;
        to = 0;
        // R2 opening waveform
        push(1, 0, 1, 1, 1, 2); push(1, 1, 1, 1, 1, 2); push(1, 0, 1, 1, 1, 2);
        push(1, 1, 1, 1, 1, 2); push(1, 1, 1, 0, 1, 2); push(1, 0, 1, 0, 1, 2);
        // R6 / R5 outbound byte order
        for (int j = 0; j < nb; j++) begin
            add_byte(bytes[j]);
            if (wr && j == 4 && noack) break; // R8
            add_ack(nk[j], to);
            if (to) break;
        end
        if (!to && !wr) begin
            add_rd(rval[7:0]);  add_mack(1'b0);
            add_rd(rval[15:8]); add_mack(1'b1);
        end
        // R9 closing waveform
        push(1, 0, 1, 0, 1, 9); push(1, 1, 1, 0, 1, 9); push(1, 1, 1, 1, 1, 9);
        push(1, 0, 1, 1, 1, 9); push(1, 1, 1, 1, 1, 9); push(1, 0, 1, 1, 1, 9);
        push(1, 1, 1, 1, 1, 9);
        exp_err = to;
        if (!wr && !to) exp_rdata = rval;

        @(negedge clk);
        start_i = 1'b1; wr_i = wr; addr_i = addr; wdata_i = wd; noack_i = noack;
        cyc = 0;
        foreach (q[s]) begin
            for (int h = 0; h < HALF; h++) begin
                @(negedge clk);
                md_i = q[s].slv;
                // R10: requests while busy carry unrelated operands
                if (poke && (cyc % 37) == 5) begin
                    start_i = 1'b1; wr_i = ~wr; addr_i = 16'hDEAD; wdata_i = 16'h5A5A; noack_i = 1'b1;
                end else begin
                    start_i = 1'b0;
                end
                chk({12'd0, mdc_oe_o, mdc_o, md_oe_o, md_o},
                    {12'd0, q[s].ck_oe, q[s].ck, q[s].d_oe, q[s].d}, int'(q[s].req), "line step");
                chk({14'd0, busy_o, done_o}, 16'b10, 10, "busy during transfer");
                cyc++;
            end
        end
        @(negedge clk);
        start_i = 1'b0; md_i = 1'b1;
        chk({14'd0, busy_o, done_o}, 16'b11, 10, "done pulse");
        chk({12'd0, mdc_oe_o, md_oe_o, mdc_o, md_o}, 16'd0, 9, "released at done");
        chk({15'd0, err_o}, {15'd0, exp_err}, 7, "timeout flag");
        chk(rdata_o, exp_rdata, 11, "read data");
        idle_check(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({12'd0, mdc_oe_o, md_oe_o, mdc_o, md_o}, 16'd0, 1, "lines in reset");
        chk({13'd0, busy_o, done_o, err_o}, 16'd0, 1, "flags in reset");
        chk(rdata_o, 16'd0, 1, "rdata in reset");
        rst_n = 1'b1;
        idle_check(3);
        // R6 plain write
        run_txn(1, 16'h1234, 16'hBEEF, 0, 0, 0, 0, 0, 0, 16'h0, 0);
        // R5 read with one retry on the address low byte
        run_txn(0, 16'h8001, 16'h0, 0, 0, 1, 0, 0, 0, 16'hA55A, 0);
        // R8 no-ack write: slave never answers the last byte
        run_txn(1, 16'h00C3, 16'h8000, 1, 0, 0, 0, 0, 6, 16'h0, 0);
        // R7 boundary: five failed polls still pass
        run_txn(1, 16'hF00F, 16'h0102, 0, 0, 0, 0, 5, 0, 16'h0, 0);
        // R7 timeout during a read; R11 rdata kept
        run_txn(0, 16'h4242, 16'h0, 0, 0, 6, 0, 0, 0, 16'h1111, 0);
        // R10 start pulses ignored mid-transfer
        run_txn(0, 16'h7E81, 16'h0, 0, 0, 0, 2, 0, 0, 16'h00FF, 1);
        // R7 timeout on the final write acknowledge
        run_txn(1, 16'h0A0B, 16'hC0DE, 0, 0, 0, 0, 0, 6, 16'h0, 0);
        // R11 err cleared by a clean read
        run_txn(0, 16'hFFFF, 16'h0, 0, 0, 0, 0, 0, 0, 16'hFE01, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule